// File: doc/BRIEF.md
# Supply-Gated Driver Enable with Power-Up Threshold Latch

This block sits between four digitized analog comparators and the two gate drivers of a synchronous rectifier controller. The comparators report whether the supply is above its turn-on level, whether the supply is above its turn-off level, and whether the shared enable/select pin is above two levels: a low select level and a higher enable level. Every flag is asynchronous to the logic clock, so each one passes through a two-flop synchronizer before it is used.

The same pin carries two pieces of information at different times. While the supply is still below its turn-on level, the block turns on a small current sink on the pin. When the synchronized supply-on flag rises, the block samples the pin once and records which turn-off drain threshold the rectifier comparators should use. That choice is then held until the supply falls below its turn-off level. Once the block is running, the pin acts as a live enable for both gate drivers. When the supply drops below the turn-off level, the drivers stop and the block goes back to startup.

Top module: `uvlo_enable_latch`

## Requirements
- R1: While rst_ni is low, sink_en_o is 1, gate_en_o is 0 and thr_sel_o is 0.
- R2: sink_en_o is 1 in the startup state and 0 in the run state. The block enters the run state on the third clock edge after supply_on_i rises, provided supply_hold_i is also high.
- R3: On entry to the run state, thr_sel_o takes the synchronized value of sel_hi_i. A value of 0 selects the deeper turn-off threshold (about -25 mV) and a value of 1 selects the shallower one (about -12.5 mV).
- R4: While the block stays in the run state, thr_sel_o does not change, whatever sel_hi_i does.
- R5: In the run state with supply_hold_i high, gate_en_o follows en_hi_i with exactly two clock cycles of latency.
- R6: In the startup state gate_en_o is 0, whatever en_hi_i and sel_hi_i do.
- R7: When the synchronized supply_hold_i goes low, gate_en_o is 0 from that cycle onward, and the block returns to the startup state on the next clock edge.
- R8: Re-entry into the run state needs a new rising edge of the synchronized supply_on_i. A supply_on_i that stays high while supply_hold_i falls and then recovers does not restart the drivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| supply_on_i | input | 1 | Supply above turn-on level (asynchronous) |
| supply_hold_i | input | 1 | Supply above turn-off level (asynchronous) |
| sel_hi_i | input | 1 | Enable pin above threshold-select level (asynchronous) |
| en_hi_i | input | 1 | Enable pin above enable level (asynchronous) |
| thr_sel_o | output | 1 | Latched turn-off threshold select (1 = shallow) |
| sink_en_o | output | 1 | Startup current sink control |
| gate_en_o | output | 1 | Gate drive permission for both drivers |

## Verification
The assertions assume a physically consistent supply: when the supply is above its turn-on level, it is also above its turn-off level. The assertions also assume that every flag, once synchronized, reflects a level held for at least one clock. The stimulus keeps to this. It raises supply_hold_i before supply_on_i, and drops supply_on_i no later than supply_hold_i, except in one deliberate case for R8 where supply_on_i is left high while supply_hold_i dips. All inputs change one nanosecond after a rising edge. The select and enable flags are toggled in both states, to show that they are frozen or ignored where the requirements say so.

// File: rtl/uvlo_enable_pkg.sv
package uvlo_enable_pkg;
  typedef enum logic {
    ST_STARTUP = 1'b0,
    ST_RUN     = 1'b1
  } pwr_state_e;

  localparam int unsigned FLAG_ON   = 0;
  localparam int unsigned FLAG_HOLD = 1;
  localparam int unsigned FLAG_SEL  = 2;
  localparam int unsigned FLAG_EN   = 3;
  localparam int unsigned NUM_FLAGS = 4;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stg_q[s] <= '0;
        end else if (s == 0) begin
          stg_q[s] <= async_i;
        end else begin
          stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[LAST];
endmodule

// File: rtl/supply_gate_fsm.sv
module supply_gate_fsm
  import uvlo_enable_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_s_i,
  input  logic hold_s_i,
  input  logic sel_s_i,
  input  logic en_s_i,
  output logic thr_sel_o,
  output logic sink_en_o,
  output logic gate_en_o
);
  pwr_state_e state_q, state_d;
  logic on_prev_q;
  logic thr_q, thr_d;
  logic on_rise;

  assign on_rise = on_s_i & ~on_prev_q;

  always_comb begin
    state_d = state_q;
    thr_d   = thr_q;
    unique case (state_q)
      ST_STARTUP: begin
        if (on_rise && hold_s_i) begin
          state_d = ST_RUN;
          thr_d   = sel_s_i;  // one-shot sample of the pin
        end
      end
      ST_RUN: begin
        if (!hold_s_i) state_d = ST_STARTUP;
      end
      default: state_d = ST_STARTUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_STARTUP;
      on_prev_q <= 1'b0;
      thr_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      on_prev_q <= on_s_i;
      thr_q     <= thr_d;
    end
  end

  assign thr_sel_o = thr_q;
  assign sink_en_o = (state_q == ST_STARTUP);
  // hold gates the output directly so undervoltage cuts drive a cycle early
  assign gate_en_o = (state_q == ST_RUN) & en_s_i & hold_s_i;

  a_r4_thr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q == ST_RUN)) |-> $stable(thr_sel_o));

  a_r6_no_gate_in_startup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sink_en_o |-> !gate_en_o);

  a_r7_hold_low_blocks_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_s_i |-> !gate_en_o);

  a_r7_exit_to_startup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !hold_s_i) |=> sink_en_o);

  a_r8_entry_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sink_en_o) |-> ($past(on_s_i) && !$past(on_prev_q) && $past(hold_s_i)));

  a_r3_thr_changes_only_at_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(thr_sel_o) |-> $fell(sink_en_o));
endmodule

// File: rtl/uvlo_enable_latch.sv
module uvlo_enable_latch
  import uvlo_enable_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_on_i,
  input  logic supply_hold_i,
  input  logic sel_hi_i,
  input  logic en_hi_i,
  output logic thr_sel_o,
  output logic sink_en_o,
  output logic gate_en_o
);
  logic [NUM_FLAGS-1:0] flags_async, flags_sync;

  always_comb begin
    flags_async            = '0;
    flags_async[FLAG_ON]   = supply_on_i;
    flags_async[FLAG_HOLD] = supply_hold_i;
    flags_async[FLAG_SEL]  = sel_hi_i;
    flags_async[FLAG_EN]   = en_hi_i;
  end

  flag_sync #(
    .WIDTH  (NUM_FLAGS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (flags_async),
    .sync_o  (flags_sync)
  );

  supply_gate_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .on_s_i    (flags_sync[FLAG_ON]),
    .hold_s_i  (flags_sync[FLAG_HOLD]),
    .sel_s_i   (flags_sync[FLAG_SEL]),
    .en_s_i    (flags_sync[FLAG_EN]),
    .thr_sel_o (thr_sel_o),
    .sink_en_o (sink_en_o),
    .gate_en_o (gate_en_o)
  );

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (sink_en_o && !gate_en_o && !thr_sel_o));
endmodule

// File: tb/tb_uvlo_enable_latch.sv
`timescale 1ns/1ps
module tb_uvlo_enable_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_i = 0, hold_i = 0, sel_i = 0, en_i = 0;
  logic thr_o, sink_o, gate_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uvlo_enable_latch dut (
    .clk_i (clk), .rst_ni (rst_n),
    .supply_on_i (on_i), .supply_hold_i (hold_i),
    .sel_hi_i (sel_i), .en_hi_i (en_i),
    .thr_sel_o (thr_o), .sink_en_o (sink_o), .gate_en_o (gate_o)
  );

  // reference model: each flag seen through a two-entry delay queue
  bit q_on[$], q_hold[$], q_sel[$], q_en[$];
  bit m_run, m_thr, m_prev;
  bit e_thr, e_sink, e_gate;

  task automatic model_reset();
    q_on = {0, 0}; q_hold = {0, 0}; q_sel = {0, 0}; q_en = {0, 0};
    m_run = 0; m_thr = 0; m_prev = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      if (m_run) begin
        if (!q_hold[1]) m_run = 0;
      end else if (q_on[1] && !m_prev && q_hold[1]) begin
        m_run = 1;
        m_thr = q_sel[1];
      end
      m_prev = q_on[1];
      q_on.push_front(on_i);     void'(q_on.pop_back());
      q_hold.push_front(hold_i); void'(q_hold.pop_back());
      q_sel.push_front(sel_i);   void'(q_sel.pop_back());
      q_en.push_front(en_i);     void'(q_en.pop_back());
    end
  end

  always_comb begin
    e_thr  = m_thr;
    e_sink = !m_run;
    e_gate = m_run && q_en[1] && q_hold[1];
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      check("R3 R4 thr_sel", thr_o, e_thr);
      check("R2 sink_en", sink_o, e_sink);
      check("R5 R6 R7 gate_en", gate_o, e_gate);
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    #1;
    check("R1 sink", sink_o, 1'b1);
    check("R1 gate", gate_o, 1'b0);
    check("R1 thr", thr_o, 1'b0);
    step(3);
    rst_n = 1;
    step(2);

    // R6 enable toggles in startup have no effect
    en_i = 1; sel_i = 1; step(4);
    check("R6 gate in startup", gate_o, 1'b0);
    en_i = 0; step(2);

    // power up with select low -> deep threshold (R3), latency (R2)
    hold_i = 1; step(3);
    on_i = 1; sel_i = 0; en_i = 1;
    step(2);
    check("R2 still startup at edge 2", sink_o, 1'b1);
    step(1);
    check("R2 run at edge 3", sink_o, 1'b0);
    check("R3 thr deep", thr_o, 1'b0);
    check("R5 gate on", gate_o, 1'b1);

    // R4 select toggles while running
    sel_i = 1; step(5);
    check("R4 thr frozen", thr_o, 1'b0);
    sel_i = 0; step(2);

    // R5 live enable, two-cycle latency
    en_i = 0; step(1);
    check("R5 gate latency 1", gate_o, 1'b1);
    step(1);
    check("R5 gate off after 2", gate_o, 1'b0);
    en_i = 1; step(3);

    // R8 hold dips with supply_on held high: back to startup, no restart
    hold_i = 0; step(2);
    check("R7 gate off at hold loss", gate_o, 1'b0);
    step(1);
    check("R7 startup after hold loss", sink_o, 1'b1);
    hold_i = 1; step(6);
    check("R8 no restart without edge", sink_o, 1'b1);

    // full power-down, then power-up with select high -> shallow threshold
    on_i = 0; hold_i = 0; step(4);
    hold_i = 1; sel_i = 1; step(2);
    on_i = 1; step(4);
    check("R3 thr shallow", thr_o, 1'b1);
    check("R2 sink off", sink_o, 1'b0);
    sel_i = 0; en_i = 0; step(4);
    check("R4 thr frozen high", thr_o, 1'b1);
    en_i = 1; step(3);

    // power-down with both supply flags together
    on_i = 0; hold_i = 0; step(5);
    check("R7 startup", sink_o, 1'b1);
    check("R6 gate off", gate_o, 1'b0);

    // reset mid-run clears the latched select (R1)
    hold_i = 1; step(2); on_i = 1; step(5);
    rst_n = 0; #1;
    check("R1 async reset thr", thr_o, 1'b0);
    check("R1 async reset sink", sink_o, 1'b1);
    step(2);
    rst_n = 1; step(6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule